// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits between the byte-load capture logic of a page-programmed flash array and the page sequencer. Every captured load (a one-cycle pulse with a 15-bit address and an 8-bit data byte) passes through it. It finds the three-byte unlock codes in that stream and marks each load as either a command byte or a data byte. Command bytes are consumed and never reach the array. For data bytes it decides whether they may write the array.

The block holds two modes. A write-protect mode, once on, blocks every page write that does not start with the enable code. A blocked load still counts as a load, so the sequencer runs its timer and status polling as usual, but nothing is written. Protection changes state only when the sequencer reports that a program cycle has finished. The second mode is a chip-identity mode. While it is active, reads of the two lowest addresses return a manufacturer byte and a device byte.

The decoder is a six-state machine:

- `S_IDLE` waits for the first key.
- `S_PFX1` means the first key has been seen.
- `S_PFX2` means both keys have been seen and a command byte is expected.
- `S_DIS_A`, `S_DIS_B` and `S_DIS_C` step through the second half of the disable code.

Its transitions are:

- **key1** (AA at 5555) moves `S_IDLE` to `S_PFX1` and `S_DIS_A` to `S_DIS_B`. It also resyncs to `S_PFX1` from any other state where it is not the expected byte.
- **key2** (55 at 2AAA) moves `S_PFX1` to `S_PFX2` and `S_DIS_B` to `S_DIS_C`.
- **op_en**, **op_idin** and **op_idout** return `S_PFX2` to `S_IDLE`.
- **op_era** moves `S_PFX2` to `S_DIS_A`.
- **op_dis** returns `S_DIS_C` to `S_IDLE`.
- **abort** (any other load) returns any state to `S_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `protect_on` and `ident_mode` are 0 and `id_hit` is 0.
- R2: A load of AA at address 5555 in `S_IDLE` is a command byte (`load_is_cmd`=1 in the same cycle). A following load of 55 at 2AAA is also a command byte.
- R3: After the prefix, a load of A0 at 5555 is a command byte. It opens a write window in which data loads give `wr_allow`=1, and it arms protection to turn on.
- R4: The disable code is the prefix, 80 at 5555, the prefix again, then 20 at 5555. All six bytes are command bytes. The code opens a write window and arms protection to turn off.
- R5: With `protect_on`=1 and no open window, a data load gives `wr_allow`=0 and `load_is_cmd`=0.
- R6: `protect_on` changes only in the cycle after a `prog_done` pulse, and only if an enable or disable code was armed.
- R7: With `protect_on`=0, every data load gives `wr_allow`=1.
- R8: After the prefix, a load of 90 at 5555 sets `ident_mode` one cycle after the load.
- R9: After the prefix, a load of F0 at 5555 clears `ident_mode` one cycle after the load.
- R10: While `ident_mode`=1 and `rd_addr[14:1]`=0, `id_hit`=1 and `id_byte` is 1F for `rd_addr[0]`=0 and DC for `rd_addr[0]`=1. Otherwise `id_hit`=0.
- R11: A load that does not match the expected step aborts the sequence and is treated as data. If that load is AA at 5555, it is a command byte and starts a new prefix.
- R12: `prog_done` closes the write window, so later unlocked data loads are blocked again while protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | One-cycle byte-load event |
| load_addr | input | 15 | Address of the load |
| load_data | input | 8 | Data of the load |
| prog_done | input | 1 | One-cycle pulse at the end of a program cycle |
| rd_addr | input | 15 | Read address for the identity lookup |
| protect_on | output | 1 | Write protection active |
| ident_mode | output | 1 | Chip-identity mode active |
| load_is_cmd | output | 1 | Current load is a command byte |
| wr_allow | output | 1 | Current load is data and may write the array |
| id_hit | output | 1 | Identity byte replaces the array read |
| id_byte | output | 8 | Identity byte |

## Verification
The per-load results (`load_is_cmd` and `wr_allow`) are combinational. They are due in the same cycle as `load_valid`. The bench drives each load on a falling edge and samples these results 1 ns later, before the capturing rising edge. `ident_mode` is due one cycle after the command load, and `protect_on` one cycle after the `prog_done` pulse. The bench samples both on the falling edge that follows that rising edge, when the register has settled. `id_hit` and `id_byte` depend only on `rd_addr` and the mode, so they are read 1 ns after `rd_addr` is driven.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PFX1,
        S_PFX2,
        S_DIS_A,
        S_DIS_B,
        S_DIS_C
    } seq_state_t;

    typedef struct packed {
        logic en;
        logic dis;
        logic id_in;
        logic id_out;
    } cmd_strobe_t;

endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR1 = 15'h5555,
    parameter logic [ADDR_W-1:0] KEY_ADDR2 = 15'h2AAA,
    parameter logic [DATA_W-1:0] KEY1      = 8'hAA,
    parameter logic [DATA_W-1:0] KEY2      = 8'h55,
    parameter logic [DATA_W-1:0] OP_EN     = 8'hA0,
    parameter logic [DATA_W-1:0] OP_ERA    = 8'h80,
    parameter logic [DATA_W-1:0] OP_DIS    = 8'h20,
    parameter logic [DATA_W-1:0] OP_IDIN   = 8'h90,
    parameter logic [DATA_W-1:0] OP_IDOUT  = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic              is_cmd,
    output cmd_strobe_t       stb
);

    seq_state_t state, nxt;
    logic hit_k1, hit_k2, at_cmd;

    assign hit_k1 = (load_addr == KEY_ADDR1) && (load_data == KEY1);
    assign hit_k2 = (load_addr == KEY_ADDR2) && (load_data == KEY2);
    assign at_cmd = (load_addr == KEY_ADDR1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state, command marking and strobes
    always_comb begin
        nxt    = state;
        is_cmd = 1'b0;
        stb    = '0;
        if (load_valid) begin
            unique case (state)
                S_IDLE: begin
                    if (hit_k1) begin nxt = S_PFX1; is_cmd = 1'b1; end
                end
                S_PFX1: begin
                    is_cmd = 1'b1;
                    if (hit_k2)      nxt = S_PFX2;
                    else if (hit_k1) nxt = S_PFX1;
                    else begin nxt = S_IDLE; is_cmd = 1'b0; end
                end
                S_PFX2: begin
                    nxt    = S_IDLE;
                    is_cmd = 1'b1;
                    if (at_cmd && load_data == OP_EN)         stb.en     = 1'b1;
                    else if (at_cmd && load_data == OP_IDIN)  stb.id_in  = 1'b1;
                    else if (at_cmd && load_data == OP_IDOUT) stb.id_out = 1'b1;
                    else if (at_cmd && load_data == OP_ERA)   nxt        = S_DIS_A;
                    else if (hit_k1)                          nxt        = S_PFX1;
                    else                                      is_cmd     = 1'b0;
                end
                S_DIS_A: begin
                    if (hit_k1) begin nxt = S_DIS_B; is_cmd = 1'b1; end
                    else nxt = S_IDLE;
                end
                S_DIS_B: begin
                    is_cmd = 1'b1;
                    if (hit_k2)      nxt = S_DIS_C;
                    else if (hit_k1) nxt = S_PFX1;
                    else begin nxt = S_IDLE; is_cmd = 1'b0; end
                end
                S_DIS_C: begin
                    is_cmd = 1'b1;
                    if (at_cmd && load_data == OP_DIS) begin
                        nxt     = S_IDLE;
                        stb.dis = 1'b1;
                    end
                    else if (hit_k1) nxt = S_PFX1;
                    else begin nxt = S_IDLE; is_cmd = 1'b0; end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // R11: a load treated as data leaves the decoder idle
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !is_cmd) |=> (state == S_IDLE));

    // R2: a completed command returns the decoder to idle
    p_cmd_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.en || stb.dis || stb.id_in || stb.id_out) |=> (state == S_IDLE));

endmodule

// File: rtl/cmd_mode_regs.sv
module cmd_mode_regs
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_valid,
    input  logic        is_cmd,
    input  cmd_strobe_t stb,
    input  logic        prog_done,
    output logic        protect_on,
    output logic        ident_mode,
    output logic        wr_allow
);

    logic win_open, arm_set, arm_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            protect_on <= 1'b0;
            ident_mode <= 1'b0;
            win_open   <= 1'b0;
            arm_set    <= 1'b0;
            arm_clr    <= 1'b0;
        end else begin
            if (prog_done) begin
                if (arm_set)      protect_on <= 1'b1;
                else if (arm_clr) protect_on <= 1'b0;
                win_open <= 1'b0;
                arm_set  <= 1'b0;
                arm_clr  <= 1'b0;
            end
            if (stb.en) begin
                win_open <= 1'b1;
                arm_set  <= 1'b1;
                arm_clr  <= 1'b0;
            end
            if (stb.dis) begin
                win_open <= 1'b1;
                arm_clr  <= 1'b1;
                arm_set  <= 1'b0;
            end
            if (stb.id_in)  ident_mode <= 1'b1;
            if (stb.id_out) ident_mode <= 1'b0;
        end
    end

    assign wr_allow = load_valid && !is_cmd && (!protect_on || win_open);

    // R6: protection only moves right after a program cycle ends
    p_prot_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (protect_on != $past(protect_on)) |-> $past(prog_done));

    // R12: a finished program cycle leaves no window open unless a new code came in
    p_window_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prog_done) && !$past(stb.en) && !$past(stb.dis)) |-> !win_open);

endmodule

// File: rtl/ident_lookup.sv
module ident_lookup #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'hDC
) (
    input  logic              ident_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_hit,
    output logic [DATA_W-1:0] id_byte
);

    assign id_hit  = ident_mode && (rd_addr[ADDR_W-1:1] == '0);
    assign id_byte = !id_hit    ? '0 :
                     rd_addr[0] ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              protect_on,
    output logic              ident_mode,
    output logic              load_is_cmd,
    output logic              wr_allow,
    output logic              id_hit,
    output logic [DATA_W-1:0] id_byte
);

    cmd_strobe_t stb;

    cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .is_cmd     (load_is_cmd),
        .stb        (stb)
    );

    cmd_mode_regs u_modes (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .is_cmd     (load_is_cmd),
        .stb        (stb),
        .prog_done  (prog_done),
        .protect_on (protect_on),
        .ident_mode (ident_mode),
        .wr_allow   (wr_allow)
    );

    ident_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ident (
        .ident_mode (ident_mode),
        .rd_addr    (rd_addr),
        .id_hit     (id_hit),
        .id_byte    (id_byte)
    );

    // R8: identity mode is entered only by the 90 command at the first key address
    p_ident_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ident_mode) |-> $past(load_valid && load_is_cmd &&
                                    load_addr == 15'h5555 && load_data == 8'h90));

    // R9: identity mode is left only by the F0 command at the first key address
    p_ident_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ident_mode) |-> $past(load_valid && load_is_cmd &&
                                    load_addr == 15'h5555 && load_data == 8'hF0));

    // R5: a consumed command byte never writes the array
    p_cmd_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_is_cmd |-> !wr_allow);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [14:0] load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        prog_done = 1'b0;
    logic [14:0] rd_addr = '0;
    logic        protect_on, ident_mode, load_is_cmd, wr_allow, id_hit;
    logic [7:0]  id_byte;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
        .load_data(load_data), .prog_done(prog_done), .rd_addr(rd_addr),
        .protect_on(protect_on), .ident_mode(ident_mode), .load_is_cmd(load_is_cmd),
        .wr_allow(wr_allow), .id_hit(id_hit), .id_byte(id_byte)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one load at a falling edge; combinational results sampled before the rising edge
    task automatic ld(input logic [14:0] a, input logic [7:0] d,
                      output logic c, output logic w);
        load_valid = 1'b1; load_addr = a; load_data = d;
        #1;
        c = load_is_cmd; w = wr_allow;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic pulse_done();
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "protect_on", protect_on, 0);
        chk("R1", "ident_mode", ident_mode, 0);
        chk("R1", "id_hit", id_hit, 0);
    endtask

    task automatic t_prefix_abort();
        logic c, w;
        ld(15'h0100, 8'h12, c, w);
        chk("R7", "plain load cmd", c, 0);
        chk("R7", "plain load wr", w, 1);
        ld(15'h5555, 8'hAA, c, w);
        chk("R2", "key1 cmd", c, 1);
        ld(15'h2AAA, 8'h55, c, w);
        chk("R2", "key2 cmd", c, 1);
        ld(15'h5555, 8'h33, c, w);
        chk("R11", "bad op cmd", c, 0);
        chk("R11", "bad op wr", w, 1);
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h1234, 8'h77, c, w);
        chk("R11", "bad key2 cmd", c, 0);
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h5555, 8'hAA, c, w);
        chk("R11", "resync key1 cmd", c, 1);
        ld(15'h2AAA, 8'h55, c, w);
        ld(15'h5555, 8'h90, c, w);
        chk("R8", "id enter cmd", c, 1);
        chk("R8", "ident after 90", ident_mode, 1);
    endtask

    task automatic t_ident();
        logic c, w;
        rd_addr = 15'h0000; #1;
        chk("R10", "hit at 0", id_hit, 1);
        chk("R10", "byte at 0", id_byte, 8'h1F);
        rd_addr = 15'h0001; #1;
        chk("R10", "byte at 1", id_byte, 8'hDC);
        rd_addr = 15'h0002; #1;
        chk("R10", "no hit at 2", id_hit, 0);
        @(negedge clk);
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h2AAA, 8'h55, c, w);
        ld(15'h5555, 8'hF0, c, w);
        chk("R9", "id exit cmd", c, 1);
        chk("R9", "ident after F0", ident_mode, 0);
        rd_addr = 15'h0000; #1;
        chk("R10", "no hit after exit", id_hit, 0);
        @(negedge clk);
    endtask

    task automatic t_enable();
        logic c, w;
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h2AAA, 8'h55, c, w);
        ld(15'h5555, 8'hA0, c, w);
        chk("R3", "enable cmd", c, 1);
        chk("R6", "protect before done", protect_on, 0);
        ld(15'h0040, 8'h5A, c, w);
        chk("R3", "window data wr", w, 1);
        pulse_done();
        chk("R3", "protect after done", protect_on, 1);
    endtask

    task automatic t_blocked();
        logic c, w;
        ld(15'h0080, 8'h11, c, w);
        chk("R5", "unlocked load wr", w, 0);
        chk("R5", "unlocked load cmd", c, 0);
        pulse_done();
        chk("R6", "protect held", protect_on, 1);
    endtask

    task automatic t_prot_write();
        logic c, w;
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h2AAA, 8'h55, c, w);
        ld(15'h5555, 8'hA0, c, w);
        ld(15'h00C0, 8'h22, c, w);
        chk("R3", "protected window wr", w, 1);
        pulse_done();
        ld(15'h00C1, 8'h23, c, w);
        chk("R12", "wr after close", w, 0);
    endtask

    task automatic t_disable();
        logic c, w;
        ld(15'h5555, 8'hAA, c, w);
        ld(15'h2AAA, 8'h55, c, w);
        ld(15'h5555, 8'h80, c, w);
        chk("R4", "erase op cmd", c, 1);
        ld(15'h5555, 8'hAA, c, w);
        chk("R4", "second key1 cmd", c, 1);
        ld(15'h2AAA, 8'h55, c, w);
        chk("R4", "second key2 cmd", c, 1);
        ld(15'h5555, 8'h20, c, w);
        chk("R4", "disable cmd", c, 1);
        chk("R6", "protect before done", protect_on, 1);
        ld(15'h0200, 8'h44, c, w);
        chk("R4", "window data wr", w, 1);
        pulse_done();
        chk("R4", "protect cleared", protect_on, 0);
        ld(15'h0300, 8'h45, c, w);
        chk("R7", "unprotected wr", w, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefix_abort();
        t_ident();
        t_enable();
        t_blocked();
        t_prot_write();
        t_disable();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule